// File: doc/BRIEF.md
# Adaptive Threshold Proximity Comparator

This block watches the stream of 12-bit results from one capacitance measurement channel and raises a proximity flag when the data moves far enough from a slowly adapting baseline. Every result arrives with a one-cycle valid strobe. All state changes happen on that strobe. In adaptive operation the block keeps an exponential running average of past results and places two thresholds around it, a programmable sensitivity above and below. Slow drift, such as temperature or humidity effects, is absorbed into the average. A fast change, such as a hand approaching the sensor, crosses a threshold.

Four comparator modes choose which region of the data activates the flag: below the band, above the band, inside the band, or outside the band. Optional hysteresis of a quarter of the sensitivity keeps the flag from chattering. Two timeouts guard against large, lasting changes. One counts results that sit outside the band toward the active threshold, and the other counts results outside the band in the opposite direction. When either timeout expires, the average is forced onto the current data. As an alternative to adaptive operation, a fixed mode compares each result against a programmed 12-bit constant.

Top module: `adapt_prox_det`

## Requirements
- R1: After reset `prox_flag` is 0 and `avg_out` is 0. The first strobe after reset loads the average with that data value, so `avg_out` equals the data and `prox_flag` stays 0. Internally the average is loaded at the middle of that integer step.
- R2: On each later strobe the average moves by (data − average) / 2^(settle+1), using an arithmetic right shift on a fixed-point average with 16 fractional bits. `avg_out` is the integer part.
- R3: In adaptive mode, `cmp_mode` = 2'b01 sets the flag when data > avg + sens, and `cmp_mode` = 2'b00 sets it when data < avg − sens. Both comparisons are strict and use the average held before the strobe.
- R4: In adaptive mode, `cmp_mode` = 2'b10 sets the flag when avg − sens < data < avg + sens. `cmp_mode` = 2'b11 sets it when data lies outside that band.
- R5: In adaptive mode with `hyst_off` = 0, a flag that is already set stays set until the data comes back past the crossed threshold by sens/4 (floor). For the below-band mode the flag releases once data ≥ avg − sens + sens/4. With `hyst_off` = 1 there is no hysteresis.
- R6: With `fixed_en` = 1, the flag is data > `fix_thr` when `cmp_mode[0]` = 1 and data < `fix_thr` when `cmp_mode[0]` = 0. Hysteresis is never applied in this mode.
- R7: In adaptive mode, each run of consecutive strobes whose data lies outside the band on the side of the active threshold is counted. Both sides count as active in the window modes. On the 2^`tout_apr`-th strobe of such a run, the average is replaced by that strobe's data.
- R8: In the above-band and below-band modes, a run of strobes outside the band on the opposite side is counted the same way. On the 2^`tout_rec`-th strobe the average is replaced by that strobe's data. The window modes never use this timeout.
- R9: When `tout_apr` and `tout_rec` are both 0, neither timeout acts. A strobe whose data is inside the band (avg − sens ≤ data ≤ avg + sens) restarts the timeout count.
- R10: Without a strobe, `prox_flag` and `avg_out` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_vld | input | 1 | One-cycle strobe marking a new result |
| data_in | input | 12 | Conversion result |
| fixed_en | input | 1 | 1 selects the fixed-threshold compare |
| cmp_mode | input | 2 | 00 below, 01 above, 10 inside band, 11 outside band |
| sens | input | 8 | Band half-width in data LSBs |
| fix_thr | input | 12 | Constant threshold for fixed mode |
| settle | input | 4 | Average time-constant select, shift = settle+1 |
| hyst_off | input | 1 | 1 disables adaptive hysteresis |
| tout_apr | input | 4 | Toward-threshold timeout exponent |
| tout_rec | input | 4 | Away-from-threshold timeout exponent |
| prox_flag | output | 1 | Proximity detected |
| avg_out | output | 12 | Integer part of the running average |

## Verification
The assertions assume that the configuration inputs stay constant across a strobe and its following cycle. They also assume that `data_vld` is a clean one-cycle pulse whose data is valid in that same cycle. The average-bound property further assumes that both timeout fields are zero, so that no snap can move the average. Each directed task sets the configuration while no strobe is active and pulses the strobe for exactly one cycle. Each task then resets the block and seeds the average before exercising a mode, so every expected value rests on a known baseline. With the slowest setting, small offsets move the average by only a fraction of an LSB, which keeps the baseline steady during the comparator tests.

// File: rtl/prox_pkg.sv
package prox_pkg;
   typedef enum logic [1:0] {
      CMP_BELOW   = 2'b00,
      CMP_ABOVE   = 2'b01,
      CMP_INSIDE  = 2'b10,
      CMP_OUTSIDE = 2'b11
   } cmp_mode_e;
endpackage

// File: rtl/prox_avg.sv
module prox_avg #(
   parameter int DW = 12,
   parameter int FW = 16,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          seed,
   input  logic          snap,
   input  logic [DW-1:0] data,
   input  logic [SW-1:0] settle,
   output logic [DW-1:0] avg
);
   localparam int AW = DW + FW;

   logic [AW-1:0]        acc;
   logic signed [AW:0]   diff;
   logic signed [AW:0]   step;
   logic [SW:0]          shamt;
   logic [AW-1:0]        load_val;

   assign load_val = {data, 1'b1, {(FW-1){1'b0}}};
   assign shamt    = {1'b0, settle} + 1'b1;
   assign diff     = $signed({1'b0, data, {FW{1'b0}}}) - $signed({1'b0, acc});
   assign step     = diff >>> shamt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (upd) begin
         if (seed || snap) acc <= load_val;
         else              acc <= acc + step[AW-1:0];
      end
   end

   assign avg = acc[AW-1:FW];
endmodule

// File: rtl/prox_cmp.sv
module prox_cmp
   import prox_pkg::*;
#(
   parameter int DW  = 12,
   parameter int SNW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd,
   input  logic           seed,
   input  logic           fixed_en,
   input  logic [1:0]     mode,
   input  logic [DW-1:0]  data,
   input  logic [DW-1:0]  avg,
   input  logic [SNW-1:0] sens,
   input  logic [DW-1:0]  thr,
   input  logic           hyst_off,
   output logic           flag,
   output logic           out_hi,
   output logic           out_lo
);
   localparam int EW = DW + 2;

   logic signed [EW-1:0] d_s, s_s, h_s, hi, lo;
   logic                 nx_adapt, nx_fixed, nx;

   assign d_s = $signed({2'b00, data});
   assign s_s = $signed({{(EW-SNW){1'b0}}, sens});
   assign h_s = hyst_off ? '0 : (s_s >>> 2);
   assign hi  = $signed({2'b00, avg}) + s_s;
   assign lo  = $signed({2'b00, avg}) - s_s;

   assign out_hi = d_s > hi;
   assign out_lo = d_s < lo;

   always_comb begin
      unique case (cmp_mode_e'(mode))
         CMP_BELOW:   nx_adapt = flag ? (d_s < lo + h_s) : out_lo;
         CMP_ABOVE:   nx_adapt = flag ? (d_s > hi - h_s) : out_hi;
         CMP_INSIDE:  nx_adapt = flag ? ((d_s > lo - h_s) && (d_s < hi + h_s))
                                      : ((d_s > lo) && (d_s < hi));
         CMP_OUTSIDE: nx_adapt = flag ? ((d_s > hi - h_s) || (d_s < lo + h_s))
                                      : (out_hi || out_lo);
         default:     nx_adapt = 1'b0;
      endcase
   end

   assign nx_fixed = mode[0] ? (data > thr) : (data < thr);
   assign nx       = fixed_en ? nx_fixed : nx_adapt;

   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (upd) flag <= seed ? 1'b0 : nx;
   end
endmodule

// File: rtl/prox_tout.sv
module prox_tout
   import prox_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          enable,
   input  logic          out_hi,
   input  logic          out_lo,
   input  logic [1:0]    mode,
   input  logic [TW-1:0] apr,
   input  logic [TW-1:0] rec,
   output logic          snap
);
   localparam int CW = (1 << TW) + 1;

   logic [CW-1:0] cnt, cnt_nx, limit;
   logic          last_hi, cur_apr, cur_rec, run;

   assign cur_apr = (out_hi && (mode == CMP_ABOVE || mode[1])) ||
                    (out_lo && (mode == CMP_BELOW || mode[1]));
   assign cur_rec = !mode[1] && ((out_hi && mode == CMP_BELOW) ||
                                 (out_lo && mode == CMP_ABOVE));
   assign run     = enable && (cur_apr || cur_rec);
   assign limit   = {{(CW-1){1'b0}}, 1'b1} << (cur_apr ? apr : rec);
   assign cnt_nx  = (cnt != '0 && last_hi == out_hi) ? cnt + 1'b1
                                                     : {{(CW-1){1'b0}}, 1'b1};
   assign snap    = upd && run && (cnt_nx == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         last_hi <= 1'b0;
      end else if (upd) begin
         cnt     <= (!run || snap) ? '0 : cnt_nx;
         last_hi <= out_hi;
      end
   end
endmodule

// File: rtl/adapt_prox_det.sv
module adapt_prox_det #(
   parameter int DATA_W = 12,
   parameter int SENS_W = 8,
   parameter int FRAC_W = 16,
   parameter int SET_W  = 4,
   parameter int TOUT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_vld,
   input  logic [DATA_W-1:0] data_in,
   input  logic              fixed_en,
   input  logic [1:0]        cmp_mode,
   input  logic [SENS_W-1:0] sens,
   input  logic [DATA_W-1:0] fix_thr,
   input  logic [SET_W-1:0]  settle,
   input  logic              hyst_off,
   input  logic [TOUT_W-1:0] tout_apr,
   input  logic [TOUT_W-1:0] tout_rec,
   output logic              prox_flag,
   output logic [DATA_W-1:0] avg_out
);
   localparam int MAX_SHIFT = 1 << SET_W;

   generate
      if (FRAC_W < MAX_SHIFT) begin : g_frac_chk
         $error("FRAC_W must cover the longest average shift");
      end
      if (SENS_W >= DATA_W) begin : g_sens_chk
         $error("SENS_W must be narrower than DATA_W");
      end
      if (TOUT_W > 5) begin : g_tout_chk
         $error("TOUT_W too large for the timeout counter");
      end
   endgenerate

   logic seeded, seed, snap, out_hi, out_lo, tout_en;

   always_ff @(posedge clk) begin
      if (!rst_n)        seeded <= 1'b0;
      else if (data_vld) seeded <= 1'b1;
   end

   assign seed    = !seeded;
   assign tout_en = seeded && !fixed_en && ((tout_apr != '0) || (tout_rec != '0));

   prox_avg #(.DW(DATA_W), .FW(FRAC_W), .SW(SET_W)) u_avg (
      .clk(clk), .rst_n(rst_n), .upd(data_vld), .seed(seed), .snap(snap),
      .data(data_in), .settle(settle), .avg(avg_out)
   );

   prox_cmp #(.DW(DATA_W), .SNW(SENS_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .upd(data_vld), .seed(seed),
      .fixed_en(fixed_en), .mode(cmp_mode), .data(data_in), .avg(avg_out),
      .sens(sens), .thr(fix_thr), .hyst_off(hyst_off), .flag(prox_flag),
      .out_hi(out_hi), .out_lo(out_lo)
   );

   prox_tout #(.TW(TOUT_W)) u_tout (
      .clk(clk), .rst_n(rst_n), .upd(data_vld), .enable(tout_en),
      .out_hi(out_hi), .out_lo(out_lo), .mode(cmp_mode),
      .apr(tout_apr), .rec(tout_rec), .snap(snap)
   );
endmodule

// File: rtl/prox_det_chk.sv
module prox_det_chk #(
   parameter int DW  = 12,
   parameter int SNW = 8,
   parameter int TW  = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           data_vld,
   input logic [DW-1:0]  data_in,
   input logic           fixed_en,
   input logic [1:0]     cmp_mode,
   input logic [SNW-1:0] sens,
   input logic [DW-1:0]  fix_thr,
   input logic           hyst_off,
   input logic [TW-1:0]  tout_apr,
   input logic [TW-1:0]  tout_rec,
   input logic           prox_flag,
   input logic [DW-1:0]  avg_out
);
   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n)        seen <= 1'b0;
      else if (data_vld) seen <= 1'b1;
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !data_vld |=> $stable(prox_flag) && $stable(avg_out)); // R10

   AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld && !seen |=> (avg_out == $past(data_in)) && !prox_flag); // R1

   AST_FIXED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld && seen && fixed_en && cmp_mode[0]
      |=> prox_flag == ($past(data_in) > $past(fix_thr))); // R6

   AST_ADAPT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld && seen && !fixed_en && cmp_mode == 2'b01 && hyst_off
      |=> prox_flag == ({1'b0, $past(data_in)} >
                        {1'b0, $past(avg_out)} + {{(DW+1-SNW){1'b0}}, $past(sens)})); // R3

   AST_AVG_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld && seen && tout_apr == '0 && tout_rec == '0 && data_in > avg_out
      |=> avg_out >= $past(avg_out) && avg_out <= $past(data_in)); // R2
endmodule

bind adapt_prox_det prox_det_chk #(.DW(DATA_W), .SNW(SENS_W), .TW(TOUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .data_vld(data_vld), .data_in(data_in),
   .fixed_en(fixed_en), .cmp_mode(cmp_mode), .sens(sens), .fix_thr(fix_thr),
   .hyst_off(hyst_off), .tout_apr(tout_apr), .tout_rec(tout_rec),
   .prox_flag(prox_flag), .avg_out(avg_out)
);

// File: tb/test_adapt_prox_det.sv
`timescale 1ns/1ps
module test_adapt_prox_det;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        data_vld = 1'b0;
   logic [11:0] data_in = '0;
   logic        fixed_en = 1'b0;
   logic [1:0]  cmp_mode = 2'b01;
   logic [7:0]  sens = 8'd40;
   logic [11:0] fix_thr = '0;
   logic [3:0]  settle = 4'd15;
   logic        hyst_off = 1'b1;
   logic [3:0]  tout_apr = '0;
   logic [3:0]  tout_rec = '0;
   logic        prox_flag;
   logic [11:0] avg_out;

   int nchk = 0;
   int nbad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   adapt_prox_det i_adapt_prox_det (
      .clk(clk), .rst_n(rst_n), .data_vld(data_vld), .data_in(data_in),
      .fixed_en(fixed_en), .cmp_mode(cmp_mode), .sens(sens), .fix_thr(fix_thr),
      .settle(settle), .hyst_off(hyst_off), .tout_apr(tout_apr),
      .tout_rec(tout_rec), .prox_flag(prox_flag), .avg_out(avg_out)
   );

   task automatic check(input string req, input int got, input int exp);
      nchk++;
      if (got != exp) begin
         nbad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic cfg(input bit fx, input logic [1:0] md, input int sn,
                      input int th, input int st, input bit ho,
                      input int ap, input int rc);
      @(negedge clk);
      fixed_en = fx; cmp_mode = md; sens = 8'(sn); fix_thr = 12'(th);
      settle = 4'(st); hyst_off = ho; tout_apr = 4'(ap); tout_rec = 4'(rc);
   endtask

   task automatic send(input int d);
      @(negedge clk);
      data_in = 12'(d); data_vld = 1'b1;
      @(negedge clk);
      data_vld = 1'b0;
   endtask

   task automatic reseed(input int d);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      send(d);
   endtask

   task automatic send_flag(input string req, input int d, input int exp);
      send(d);
      check(req, int'(prox_flag), exp);
   endtask

   task automatic t_reset;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 flag after reset", int'(prox_flag), 0);
      check("R1 avg after reset", int'(avg_out), 0);
      send(1000);
      check("R1 seed avg", int'(avg_out), 1000);
      check("R1 seed flag", int'(prox_flag), 0);
   endtask

   task automatic t_above;
      cfg(0, 2'b01, 40, 0, 15, 1, 0, 0);
      reseed(1000);
      send_flag("R3 above 1041", 1041, 1);
      send_flag("R3 above 1040", 1040, 0);
      send_flag("R3 above 1041 again", 1041, 1);
      @(negedge clk); data_in = 12'd0; cmp_mode = 2'b00; fixed_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 flag held", int'(prox_flag), 1);
      check("R10 avg held", int'(avg_out), 1000);
      cfg(0, 2'b01, 40, 0, 15, 1, 0, 0);
      send_flag("R3 above back to base", 1000, 0);
   endtask

   task automatic t_below;
      cfg(0, 2'b00, 40, 0, 15, 1, 0, 0);
      reseed(1000);
      send_flag("R3 below 960", 960, 0);
      send_flag("R3 below 959", 959, 1);
      send_flag("R3 below 960 no hyst", 960, 0);
      cfg(0, 2'b00, 40, 0, 15, 0, 0, 0);
      reseed(1000);
      send_flag("R5 set 959", 959, 1);
      send_flag("R5 hold 965", 965, 1);
      send_flag("R5 release 970", 970, 0);
      send_flag("R5 stay clear 965", 965, 0);
   endtask

   task automatic t_window;
      cfg(0, 2'b10, 40, 0, 15, 1, 0, 0);
      reseed(1000);
      send_flag("R4 inside 1000", 1000, 1);
      send_flag("R4 inside 1039", 1039, 1);
      send_flag("R4 edge 1040", 1040, 0);
      send_flag("R4 inside 961", 961, 1);
      send_flag("R4 edge 960", 960, 0);
      cfg(0, 2'b11, 40, 0, 15, 0, 0, 0);
      reseed(1000);
      send_flag("R4 outside 1041", 1041, 1);
      send_flag("R5 outside hold 1035", 1035, 1);
      send_flag("R5 outside release 1030", 1030, 0);
      send_flag("R4 outside 955", 955, 1);
      send_flag("R5 outside hold 965", 965, 1);
      send_flag("R5 outside release 980", 980, 0);
   endtask

   task automatic t_fixed;
      cfg(1, 2'b01, 40, 500, 15, 0, 0, 0);
      reseed(1000);
      send_flag("R6 above 501", 501, 1);
      send_flag("R6 above 500", 500, 0);
      send_flag("R6 above 501 again", 501, 1);
      send_flag("R6 no hyst 499", 499, 0);
      cfg(1, 2'b00, 40, 500, 15, 0, 0, 0);
      send_flag("R6 below 499", 499, 1);
      send_flag("R6 below 500", 500, 0);
      cfg(1, 2'b10, 40, 500, 15, 0, 0, 0);
      send_flag("R6 mode10 acts below", 499, 1);
      cfg(1, 2'b11, 40, 500, 15, 0, 0, 0);
      send_flag("R6 mode11 acts above", 501, 1);
   endtask

   task automatic t_approach;
      cfg(0, 2'b01, 40, 0, 15, 1, 2, 15);
      reseed(1000);
      for (int i = 0; i < 3; i++) begin
         send_flag("R7 flag during run", 1100, 1);
      end
      check("R7 avg before timeout", int'(avg_out), 1000);
      send_flag("R7 flag on timeout strobe", 1100, 1);
      check("R7 avg snapped", int'(avg_out), 1100);
      send_flag("R7 flag after snap", 1100, 0);
   endtask

   task automatic t_recede;
      cfg(0, 2'b01, 40, 0, 15, 1, 15, 1);
      reseed(1000);
      send(900);
      check("R8 avg after one", int'(avg_out), 1000);
      send(900);
      check("R8 avg snapped", int'(avg_out), 900);
      check("R8 flag", int'(prox_flag), 0);
      cfg(0, 2'b10, 40, 0, 15, 1, 15, 1);
      reseed(1000);
      send(900); send(900); send(900);
      check("R8 window ignores receding", int'(avg_out), 1000);
   endtask

   task automatic t_disable;
      cfg(0, 2'b01, 40, 0, 15, 1, 0, 0);
      reseed(1000);
      for (int i = 0; i < 5; i++) send(1100);
      check("R9 zero byte no snap", int'(avg_out), 1000);
      cfg(0, 2'b01, 40, 0, 15, 1, 0, 1);
      reseed(1000);
      send(1100);
      check("R7 exponent zero snaps at once", int'(avg_out), 1100);
      cfg(0, 2'b01, 40, 0, 15, 1, 2, 15);
      reseed(1000);
      for (int i = 0; i < 3; i++) send(1100);
      send(1000);
      for (int i = 0; i < 3; i++) send(1100);
      check("R9 count restarted", int'(avg_out), 1000);
      send(1100);
      check("R9 snap after full run", int'(avg_out), 1100);
   endtask

   task automatic t_average;
      cfg(0, 2'b01, 255, 0, 0, 1, 0, 0);
      reseed(1000);
      send(2000);
      check("R2 shift1 step1", int'(avg_out), 1500);
      send(2000);
      check("R2 shift1 step2", int'(avg_out), 1750);
      cfg(0, 2'b01, 255, 0, 2, 1, 0, 0);
      reseed(1000);
      send(1800);
      check("R2 shift3 step", int'(avg_out), 1100);
   endtask

   initial begin
      t_reset();
      t_above();
      t_below();
      t_window();
      t_fixed();
      t_approach();
      t_recede();
      t_disable();
      t_average();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nbad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule